// File: doc/BRIEF.md
# I2C SCL timing generator

This block turns a system clock into the serial clock of an I2C master. It drives SCL low for the low phase and releases it for the high phase. It marks two points in every bit period with one-cycle strobes. The first is the cycle in which the byte engine may change SDA, once the hold delay after the falling edge has passed. The second is the cycle in which SDA should be sampled, at the middle of the high phase. Two timing modes are provided. Standard mode uses one 9-bit quarter-period divider, held as a 7-bit low field and a 2-bit high field. Fast mode uses independent low-phase and high-phase counts, each in units of two clocks, plus a separate SDA hold count.

The generator watches the real SCL line through a synchroniser, so a slave that stretches the clock pauses the high phase. The high-phase counter runs freely only for the synchroniser's own latency. After that it freezes for as long as the synchronised line reads low. In this way a bit period with no stretching keeps its programmed length, and a stretch lengthens the high phase by exactly the number of cycles the line is held. All inputs are plain control levels sampled every cycle. No handshake exists: the strobes are pulses that the byte engine must act on in the cycle they appear.

Top module: `i2c_scl_timegen`

## Requirements
- R1: While reset is asserted, and while `run` is low, `scl_out` is 1 (released) and neither strobe fires.
- R2: In standard mode (`fast_mode`=0) the divider is D = {`div_hi`,`div_lo`}, with `div_hi` as bits 8:7. The low phase lasts 2·D clocks and the high phase lasts 2·D clocks, so the period is 4·D.
- R3: In standard mode a divider of 0 acts as 1, giving a 2-clock low phase and a 2-clock high phase.
- R4: In fast mode the low phase lasts 2·`fast_low` clocks and the high phase lasts 2·`fast_high` clocks.
- R5: In fast mode a low or high count of 0 acts as 1 (2 clocks).
- R6: In fast mode `sda_chg_stb` fires once per period, `fast_hold` clocks after the first low cycle. It is clamped to the last low cycle when `fast_hold` ≥ the low length, and a hold of 0 fires in the first low cycle.
- R7: In standard mode `sda_chg_stb` fires once per period, D clocks after the first low cycle.
- R8: `sample_stb` fires once per period, H/2 clocks after the first high cycle, where H is the high-phase length in clocks.
- R9: If a slave keeps SCL low for k clocks beyond the synchroniser latency after release, the high phase grows by k clocks. A sample point that lies at or after the latency moves by k clocks as well.
- R10: Dropping `run` during a period returns `scl_out` to 1 on the next clock, with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables clock generation; low means idle and released |
| fast_mode | input | 1 | 0: standard divider timing, 1: fast-mode counts |
| div_lo | input | 7 | Standard divider, bits 6:0 |
| div_hi | input | 2 | Standard divider, bits 8:7 |
| fast_low | input | 8 | Fast low phase, in units of 2 clocks |
| fast_high | input | 8 | Fast high phase, in units of 2 clocks |
| fast_hold | input | 8 | Fast SDA hold, in clocks after the falling edge |
| scl_in | input | 1 | Level of the SCL line as seen on the pin |
| scl_out | output | 1 | 0 drives SCL low, 1 releases it |
| sda_chg_stb | output | 1 | One-cycle pulse: SDA may change now |
| sample_stb | output | 1 | One-cycle pulse: sample SDA now |

## Verification
Two functions can fall in the same cycle here. One is the release of a stretched clock: the counter resumes in the cycle the synchronised line turns high. The other is the midpoint sample, which fires in that very cycle when the midpoint equals the synchroniser latency. The bench provokes this with a 4-clock fast high phase and a slave that holds the line for several cycles. It expects the sample offset and the high length both to grow by exactly the stretch. A second coincidence, a hold of 0 that puts the SDA strobe in the cycle SCL falls, is judged by requiring an offset of zero from the observed falling edge.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } tg_phase_e;
endpackage

// File: rtl/tg_line_sync.sv
module tg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr <= '1;
        end else begin
          sr[0] <= d;
          for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
        end
      end
      assign q = sr[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tg_phase_len.sv
module tg_phase_len #(
  parameter int LO_W  = 7,
  parameter int HI_W  = 2,
  parameter int CNT_W = 8,
  parameter int LEN_W = 10
) (
  input  logic             fast_mode,
  input  logic [LO_W-1:0]  div_lo,
  input  logic [HI_W-1:0]  div_hi,
  input  logic [CNT_W-1:0] fast_low,
  input  logic [CNT_W-1:0] fast_high,
  input  logic [CNT_W-1:0] fast_hold,
  output logic [LEN_W-1:0] low_len,
  output logic [LEN_W-1:0] high_len,
  output logic [LEN_W-1:0] hold_pt,
  output logic [LEN_W-1:0] mid_pt
);
  localparam int DIV_W = LO_W + HI_W;

  logic [DIV_W-1:0] div_raw, div_eff;
  logic [CNT_W-1:0] fl_eff, fh_eff;
  logic [LEN_W-1:0] std_len, f_low_len, f_high_len, f_hold_ext;

  always_comb begin
    div_raw    = {div_hi, div_lo};
    div_eff    = (div_raw == '0) ? DIV_W'(1) : div_raw;
    fl_eff     = (fast_low  == '0) ? CNT_W'(1) : fast_low;
    fh_eff     = (fast_high == '0) ? CNT_W'(1) : fast_high;
    std_len    = LEN_W'(div_eff) << 1;
    f_low_len  = LEN_W'(fl_eff) << 1;
    f_high_len = LEN_W'(fh_eff) << 1;
    f_hold_ext = LEN_W'(fast_hold);

    if (fast_mode) begin
      low_len  = f_low_len;
      high_len = f_high_len;
      hold_pt  = (f_hold_ext >= f_low_len) ? (f_low_len - LEN_W'(1)) : f_hold_ext;
    end else begin
      low_len  = std_len;
      high_len = std_len;
      hold_pt  = LEN_W'(div_eff);
    end
    mid_pt = high_len >> 1;
  end
endmodule

// File: rtl/tg_phase_fsm.sv
module tg_phase_fsm
  import i2c_tg_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             line_hi,
  input  logic [LEN_W-1:0] low_len,
  input  logic [LEN_W-1:0] high_len,
  input  logic [LEN_W-1:0] hold_pt,
  input  logic [LEN_W-1:0] mid_pt,
  output logic             scl_out,
  output logic             sda_chg_stb,
  output logic             sample_stb
);
  localparam logic [LEN_W-1:0] SYNC_L = LEN_W'(SYNC);
  localparam logic [LEN_W-1:0] ONE    = LEN_W'(1);

  tg_phase_e        phase_q, phase_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             advance, low_done, high_done;

  always_comb begin
    advance   = (cnt_q < SYNC_L) || line_hi;
    low_done  = cnt_q >= (low_len - ONE);
    high_done = cnt_q >= (high_len - ONE);
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    case (phase_q)
      PH_IDLE: begin
        phase_d = PH_LOW;
        cnt_d   = '0;
      end
      PH_LOW: begin
        if (low_done) begin
          phase_d = PH_HIGH;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
      PH_HIGH: begin
        if (advance) begin
          if (high_done) begin
            phase_d = PH_LOW;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
    if (!run) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign scl_out     = (phase_q != PH_LOW);
  assign sda_chg_stb = run && (phase_q == PH_LOW) && (cnt_q == hold_pt);
  assign sample_stb  = run && (phase_q == PH_HIGH) && advance && (cnt_q == mid_pt);

  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> scl_out)
    else $error("scl not released after run dropped");

  assert_low_to_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase_q == PH_LOW && low_done) |=> (phase_q == PH_HIGH))
    else $error("low phase did not end on its count");

  assert_min_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $rose(phase_q == PH_LOW)) |=> (phase_q == PH_LOW))
    else $error("low phase shorter than two clocks");

  assert_stretch_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase_q == PH_HIGH && cnt_q >= SYNC_L && !line_hi)
      |=> (phase_q == PH_HIGH && $stable(cnt_q)))
    else $error("high counter moved while line held low");

  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HIGH && $past(phase_q) == PH_HIGH)
      |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE))
    else $error("high counter jumped");

  assert_hold_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hold_pt < low_len))
    else $error("hold point outside low phase");
endmodule

// File: rtl/i2c_scl_timegen.sv
module i2c_scl_timegen #(
  parameter int DIV_LO_W    = 7,
  parameter int DIV_HI_W    = 2,
  parameter int FCNT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                fast_mode,
  input  logic [DIV_LO_W-1:0] div_lo,
  input  logic [DIV_HI_W-1:0] div_hi,
  input  logic [FCNT_W-1:0]   fast_low,
  input  logic [FCNT_W-1:0]   fast_high,
  input  logic [FCNT_W-1:0]   fast_hold,
  input  logic                scl_in,
  output logic                scl_out,
  output logic                sda_chg_stb,
  output logic                sample_stb
);
  localparam int DIV_W = DIV_LO_W + DIV_HI_W;
  localparam int LEN_W = ((DIV_W > FCNT_W) ? DIV_W : FCNT_W) + 1;

  logic             line_hi;
  logic [LEN_W-1:0] low_len, high_len, hold_pt, mid_pt;

  tg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (scl_in),
    .q     (line_hi)
  );

  tg_phase_len #(
    .LO_W  (DIV_LO_W),
    .HI_W  (DIV_HI_W),
    .CNT_W (FCNT_W),
    .LEN_W (LEN_W)
  ) u_len (
    .fast_mode (fast_mode),
    .div_lo    (div_lo),
    .div_hi    (div_hi),
    .fast_low  (fast_low),
    .fast_high (fast_high),
    .fast_hold (fast_hold),
    .low_len   (low_len),
    .high_len  (high_len),
    .hold_pt   (hold_pt),
    .mid_pt    (mid_pt)
  );

  tg_phase_fsm #(.LEN_W(LEN_W), .SYNC(SYNC_STAGES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .line_hi     (line_hi),
    .low_len     (low_len),
    .high_len    (high_len),
    .hold_pt     (hold_pt),
    .mid_pt      (mid_pt),
    .scl_out     (scl_out),
    .sda_chg_stb (sda_chg_stb),
    .sample_stb  (sample_stb)
  );
endmodule

// File: tb/sim_i2c_scl_timegen.sv
module sim_i2c_scl_timegen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       fast_mode = 1'b0;
  logic [6:0] div_lo = '0;
  logic [1:0] div_hi = '0;
  logic [7:0] fast_low = '0, fast_high = '0, fast_hold = '0;
  logic       scl_in;
  logic       scl_out, sda_chg_stb, sample_stb;

  always #5 clk = ~clk;

  int stretch_k = 0;
  int left = 0;
  assign scl_in = scl_out & (left == 0);

  always @(negedge clk) begin
    if (!scl_out) left <= stretch_k;
    else if (left > 0) left <= left - 1;
  end

  i2c_scl_timegen u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .fast_mode(fast_mode),
    .div_lo(div_lo), .div_hi(div_hi), .fast_low(fast_low),
    .fast_high(fast_high), .fast_hold(fast_hold), .scl_in(scl_in),
    .scl_out(scl_out), .sda_chg_stb(sda_chg_stb), .sample_stb(sample_stb)
  );

  typedef struct {
    int low; int high; int hold; int samp; bit fast; bit str;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: measures each complete period and compares with the queue head
  int  cyc = 0, t_fall, t_rise, t_sda, t_samp, n_sda, n_samp;
  bit  prev_scl = 1'b1, have_fall = 1'b0, have_rise = 1'b0;
  always @(posedge clk) begin
    #2;
    cyc++;
    if (!rst_n || !run) begin
      have_fall = 1'b0; have_rise = 1'b0; prev_scl = scl_out;
    end else begin
      if (prev_scl && !scl_out) begin
        if (have_fall && have_rise) begin
          if (q.size() == 0) begin
            chk(1'b0, "R2 unexpected period", 1, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk((t_rise - t_fall) == e.low, e.fast ? "R4/R5 low" : "R2/R3 low", t_rise - t_fall, e.low);
            chk((cyc - t_rise) == e.high, e.str ? "R9 high" : (e.fast ? "R4/R5 high" : "R2/R3 high"), cyc - t_rise, e.high);
            chk(n_sda == 1 && (t_sda - t_fall) == e.hold, e.fast ? "R6 hold" : "R7 hold", t_sda - t_fall, e.hold);
            chk(n_samp == 1 && (t_samp - t_rise) == e.samp, e.str ? "R9 sample" : "R8 sample", t_samp - t_rise, e.samp);
          end
        end
        have_fall = 1'b1; have_rise = 1'b0; t_fall = cyc; n_sda = 0; n_samp = 0;
      end
      if (!prev_scl && scl_out && have_fall) begin
        have_rise = 1'b1; t_rise = cyc;
      end
      if (sda_chg_stb) begin if (n_sda == 0) t_sda = cyc; n_sda++; end
      if (sample_stb) begin if (n_samp == 0) t_samp = cyc; n_samp++; end
      prev_scl = scl_out;
    end
  end

  // driver: program, push expected periods, wait until all are consumed
  task automatic run_cfg(input bit fm, input int lo7, input int hi2, input int fl,
                         input int fh, input int fhd, input int s, input int nper,
                         input int e_low, input int e_high, input int e_hold, input int e_samp);
    exp_t e;
    @(negedge clk);
    fast_mode = fm; div_lo = 7'(lo7); div_hi = 2'(hi2);
    fast_low = 8'(fl); fast_high = 8'(fh); fast_hold = 8'(fhd);
    stretch_k = s;
    e.low = e_low; e.high = e_high; e.hold = e_hold; e.samp = e_samp;
    e.fast = fm; e.str = (s > 1);
    for (int i = 0; i < nper; i++) q.push_back(e);
    run = 1'b1;
    while (q.size() != 0) @(negedge clk);
    run = 1'b0;
    stretch_k = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(scl_out == 1'b1, "R1 reset scl", scl_out, 1);
    chk(!sda_chg_stb && !sample_stb, "R1 reset strobes", sda_chg_stb | sample_stb, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(scl_out == 1'b1 && !sda_chg_stb && !sample_stb, "R1 idle", scl_out, 1);

    // R2/R7/R8 standard divider 5
    run_cfg(1'b0, 5, 0, 0, 0, 0, 0, 3, 10, 10, 5, 5);
    // R2 divider 130 crosses into the upper field (div_hi=1, div_lo=2)
    run_cfg(1'b0, 2, 1, 0, 0, 0, 0, 2, 260, 260, 130, 130);
    // R3 divider 0 acts as 1
    run_cfg(1'b0, 0, 0, 0, 0, 0, 0, 3, 2, 2, 1, 1);
    // R4/R6 fast counts 16/11, hold 7
    run_cfg(1'b1, 0, 0, 16, 11, 7, 0, 3, 32, 22, 7, 11);
    // R4/R6 fast counts 7/5, hold 7
    run_cfg(1'b1, 0, 0, 7, 5, 7, 0, 3, 14, 10, 7, 5);
    // R6 hold clamped to last low cycle
    run_cfg(1'b1, 0, 0, 3, 4, 20, 0, 2, 6, 8, 5, 4);
    // R5 zero counts, R6 hold 0 in the falling-edge cycle
    run_cfg(1'b1, 0, 0, 0, 0, 0, 0, 3, 2, 2, 0, 1);
    // R9 stretch of 4 extra clocks in fast mode
    run_cfg(1'b1, 0, 0, 4, 6, 2, 5, 2, 8, 16, 2, 10);
    // R9 coincidence: sample point equals sync latency, released by stretch
    run_cfg(1'b1, 0, 0, 3, 2, 1, 4, 2, 6, 7, 1, 5);
    // R9 stretch in standard mode
    run_cfg(1'b0, 5, 0, 0, 0, 0, 3, 2, 10, 12, 5, 7);

    // R10: abort in the middle of a low phase
    @(negedge clk);
    fast_mode = 1'b0; div_lo = 7'd5; div_hi = 2'd0;
    run = 1'b1;
    while (scl_out) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk(scl_out == 1'b1, "R10 abort scl", scl_out, 1);
    chk(!sda_chg_stb && !sample_stb, "R10 abort strobes", sda_chg_stb | sample_stb, 0);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2 queue drained", q.size(), 0);
    finish_run();
  end
endmodule